// File: doc/BRIEF.md
# Burst-Capable Slow-Memory Store Unit

This block carries out store instructions aimed at a slow memory built from 32-bit words. Instruction decode has already resolved the register operands, so each issued store arrives with its decoded control fields, the value of the data register, the value of the base address register and the PC of the issuing instruction. One cycle later the block drives a word address, a 32-bit write word and a two-bit write enable. Each enable bit covers one 16-bit half of the word.

A single store goes to base plus the immediate offset. It writes in one of four ways: a full word tagged with the PC, the upper half only, the lower half only, or one half holding a 2-bit label above 14 data bits. A burst store ignores the immediate. It goes to base plus an internal offset that a set-offset instruction loaded earlier, and that offset moves forward by itself. A full-word burst writes one word per store. A half-word burst fills the high half on one store and the low half on the next, and only then moves to the next word.

Top module: `slowmem_store_unit`

## Requirements
- R1: After reset, the write enable, address and write word are all zero, the internal offset is 0 and the next half-word burst store writes the high half.
- R2: An issued manual store in mode 0 writes `{pc[10:0], 5'b0, data[15:0]}` with enable `2'b11` to address `(base + imm) mod 2^11`. The write appears on the outputs in the cycle after issue.
- R3: A manual store in mode 3 places `data[15:0]` in bits 31:16 with enable `2'b10` when upper=1, and in bits 15:0 with enable `2'b01` when upper=0. The other half of the write word is zero.
- R4: A manual store in mode 1 writes the half-word `{label[1:0], data[13:0]}` into the half selected by upper, with the enable and zero fill rules of R3.
- R5: A set-offset store loads the 11-bit immediate into the internal offset and clears the half-word phase, so the next half-word burst writes the high half. It produces no write.
- R6: An auto store in mode 0 writes the PC-tagged word of R2 to `(base + internal offset) mod 2^11` and then adds 1 to the internal offset.
- R7: An auto store in mode 3 writes data to the high half (enable `2'b10`) at `base + offset` when the phase is clear, then sets the phase. When the phase is set, it writes to the low half (enable `2'b01`), clears the phase and adds 1 to the offset.
- R8: When several enables are set on one store, set-offset wins over manual, and manual wins over auto.
- R9: An issued store with no enable set, or with a mode it does not define, writes nothing and leaves the offset and phase unchanged. For manual stores the undefined mode is 2. For auto stores the undefined modes are 1 and 2.
- R10: The internal offset and every address wrap modulo 2^11. An offset of 2047 plus 1 gives 0.
- R11: In a cycle where no store is issued, the following cycle shows enable `2'b00`, whatever the field inputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| st_fire | input | 1 | A store instruction is issued this cycle |
| st_set_ofs | input | 1 | Set-offset enable field |
| st_manual | input | 1 | Single (manual) store enable field |
| st_auto | input | 1 | Burst (auto) store enable field |
| st_mode | input | 2 | Write mode field: 0 full word, 1 labelled half, 3 plain half |
| st_upper | input | 1 | Half select for single half stores: 1 upper, 0 lower |
| st_label | input | 2 | Label for mode 1 stores |
| st_imm | input | 11 | Immediate offset, or the new burst offset for set-offset |
| base_addr | input | 11 | Base register value (word address) |
| data_val | input | 16 | Data register value |
| pc_val | input | 11 | PC of the issuing instruction |
| mem_we | output | 2 | Write enable per half: bit 1 for 31:16, bit 0 for 15:0 |
| mem_addr | output | 11 | Word address of the write |
| mem_wdata | output | 32 | Write word |

## Verification
The risky overlap is a set-offset store arriving between the two halves of a half-word burst pair. In that cycle the offset reload and the phase clear compete with the pending low-half write and its offset advance. The bench issues a high-half burst, then a set-offset, then another half-word burst. The model expects that last store to write the high half at the new offset, and expects no advance of the old offset. Stores that set several enables at once and pass through the wrap at 2047 are judged the same way. The behavioural model is compared against the outputs on every cycle.

// File: rtl/slst_pkg.sv
package slst_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  localparam int PC_W   = 11;
  localparam int LBL_W  = 2;
  localparam int PAD_W  = WORD_W - PC_W - HALF_W;

  localparam logic [1:0] MODE_FULL  = 2'd0;
  localparam logic [1:0] MODE_LABEL = 2'd1;
  localparam logic [1:0] MODE_HALF  = 2'd3;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SETOFS,
    OP_SGL_FULL,
    OP_SGL_LABEL,
    OP_SGL_HALF,
    OP_BST_FULL,
    OP_BST_HALF
  } st_op_e;

  function automatic logic [WORD_W-1:0] pc_tag_word(input logic [PC_W-1:0] pc,
                                                    input logic [HALF_W-1:0] d);
    return {pc, {PAD_W{1'b0}}, d};
  endfunction

  function automatic logic [HALF_W-1:0] label_half(input logic [LBL_W-1:0] lbl,
                                                   input logic [HALF_W-1:0] d);
    return {lbl, d[HALF_W-LBL_W-1:0]};
  endfunction

  function automatic logic [WORD_W-1:0] place_half(input logic [HALF_W-1:0] h,
                                                   input logic upper);
    return upper ? {h, {HALF_W{1'b0}}} : {{HALF_W{1'b0}}, h};
  endfunction

  function automatic logic [1:0] half_enable(input logic upper);
    return upper ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/slst_decode.sv
module slst_decode
  import slst_pkg::*;
(
  input  logic       fire,
  input  logic       set_ofs,
  input  logic       manual,
  input  logic       auto_en,
  input  logic [1:0] mode,
  output st_op_e     op
);
  always_comb begin
    op = OP_NONE;
    if (fire) begin
      if (set_ofs) begin
        op = OP_SETOFS;
      end else if (manual) begin
        if (mode == MODE_FULL)       op = OP_SGL_FULL;
        else if (mode == MODE_LABEL) op = OP_SGL_LABEL;
        else if (mode == MODE_HALF)  op = OP_SGL_HALF;
      end else if (auto_en) begin
        if (mode == MODE_FULL)       op = OP_BST_FULL;
        else if (mode == MODE_HALF)  op = OP_BST_HALF;
      end
    end
  end
endmodule

// File: rtl/slst_burst_ofs.sv
module slst_burst_ofs
  import slst_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  st_op_e            op,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] ofs,
  output logic              phase_lo
);
  logic adv_evt;
  logic flip_evt;

  assign adv_evt  = (op == OP_BST_FULL) || ((op == OP_BST_HALF) && phase_lo);
  assign flip_evt = (op == OP_BST_HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs      <= '0;
      phase_lo <= 1'b0;
    end else if (op == OP_SETOFS) begin
      ofs      <= load_val;
      phase_lo <= 1'b0;
    end else begin
      if (adv_evt)  ofs      <= ofs + ADDR_W'(1);
      if (flip_evt) phase_lo <= ~phase_lo;
    end
  end

  AST_OFS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SETOFS) |=> (ofs == $past(load_val)) && !phase_lo); // R5
  AST_PAIR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BST_HALF && phase_lo) |=> (ofs == $past(ofs) + ADDR_W'(1)) && !phase_lo); // R7
  AST_FIRST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BST_HALF && !phase_lo) |=> $stable(ofs) && phase_lo); // R7
  AST_FULL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BST_FULL) |=> (ofs == $past(ofs) + ADDR_W'(1))); // R6
  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NONE) |=> $stable(ofs) && $stable(phase_lo)); // R9
endmodule

// File: rtl/slst_wr_stage.sv
module slst_wr_stage
  import slst_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  st_op_e            op,
  input  logic              upper,
  input  logic [LBL_W-1:0]  label,
  input  logic [ADDR_W-1:0] imm,
  input  logic [ADDR_W-1:0] base,
  input  logic [HALF_W-1:0] data,
  input  logic [PC_W-1:0]   pc,
  input  logic [ADDR_W-1:0] ofs,
  input  logic              phase_lo,
  output logic [1:0]        mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata
);
  logic              is_burst;
  logic [ADDR_W-1:0] eff_ofs;
  logic [ADDR_W-1:0] nxt_addr;
  logic [WORD_W-1:0] nxt_data;
  logic [1:0]        nxt_we;

  assign is_burst = (op == OP_BST_FULL) || (op == OP_BST_HALF);
  assign eff_ofs  = is_burst ? ofs : imm;
  assign nxt_addr = base + eff_ofs;

  always_comb begin
    nxt_we   = 2'b00;
    nxt_data = '0;
    case (op)
      OP_SGL_FULL, OP_BST_FULL: begin
        nxt_we   = 2'b11;
        nxt_data = pc_tag_word(pc, data);
      end
      OP_SGL_LABEL: begin
        nxt_we   = half_enable(upper);
        nxt_data = place_half(label_half(label, data), upper);
      end
      OP_SGL_HALF: begin
        nxt_we   = half_enable(upper);
        nxt_data = place_half(data, upper);
      end
      OP_BST_HALF: begin
        nxt_we   = half_enable(!phase_lo);
        nxt_data = place_half(data, !phase_lo);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we    <= 2'b00;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= nxt_we;
      if (nxt_we != 2'b00) begin
        mem_addr  <= nxt_addr;
        mem_wdata <= nxt_data;
      end
    end
  end

  AST_FULL_BOTH_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SGL_FULL || op == OP_BST_FULL) |=> (mem_we == 2'b11)); // R2
  AST_HALF_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SGL_HALF || op == OP_SGL_LABEL || op == OP_BST_HALF)
      |=> ($countones(mem_we) == 1)); // R3
  AST_BURST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    is_burst |=> (mem_addr == $past(base) + $past(ofs))); // R6
  AST_SETOFS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SETOFS) |=> (mem_we == 2'b00)); // R5
endmodule

// File: rtl/slowmem_store_unit.sv
module slowmem_store_unit
  import slst_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_fire,
  input  logic              st_set_ofs,
  input  logic              st_manual,
  input  logic              st_auto,
  input  logic [1:0]        st_mode,
  input  logic              st_upper,
  input  logic [1:0]        st_label,
  input  logic [ADDR_W-1:0] st_imm,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [15:0]       data_val,
  input  logic [10:0]       pc_val,
  output logic [1:0]        mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata
);
  st_op_e            op;
  logic [ADDR_W-1:0] burst_ofs;
  logic              burst_phase_lo;

  slst_decode u_decode (
    .fire    (st_fire),
    .set_ofs (st_set_ofs),
    .manual  (st_manual),
    .auto_en (st_auto),
    .mode    (st_mode),
    .op      (op)
  );

  slst_burst_ofs #(.ADDR_W(ADDR_W)) u_ofs (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .load_val (st_imm),
    .ofs      (burst_ofs),
    .phase_lo (burst_phase_lo)
  );

  slst_wr_stage #(.ADDR_W(ADDR_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .upper     (st_upper),
    .label     (st_label),
    .imm       (st_imm),
    .base      (base_addr),
    .data      (data_val),
    .pc        (pc_val),
    .ofs       (burst_ofs),
    .phase_lo  (burst_phase_lo),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !st_fire |=> (mem_we == 2'b00)); // R11
  AST_PRIORITY_SETOFS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fire && st_set_ofs) |=> (mem_we == 2'b00)); // R8
endmodule

// File: tb/slowmem_store_unit_test.sv
module slowmem_store_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_fire = 0, st_set_ofs = 0, st_manual = 0, st_auto = 0, st_upper = 0;
  logic [1:0]  st_mode = 0, st_label = 0;
  logic [10:0] st_imm = 0, base_addr = 0, pc_val = 0;
  logic [15:0] data_val = 0;
  logic [1:0]  mem_we;
  logic [10:0] mem_addr;
  logic [31:0] mem_wdata;

  always #4 clk = ~clk;

  slowmem_store_unit uut (
    .clk(clk), .rst_n(rst_n), .st_fire(st_fire), .st_set_ofs(st_set_ofs),
    .st_manual(st_manual), .st_auto(st_auto), .st_mode(st_mode), .st_upper(st_upper),
    .st_label(st_label), .st_imm(st_imm), .base_addr(base_addr), .data_val(data_val),
    .pc_val(pc_val), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  int m_ofs = 0;
  bit m_lo  = 0;
  int e_we = 0, e_addr = 0;
  logic [31:0] e_data = 0;

  task automatic check(string tag);
    checks++;
    if (mem_we !== 2'(e_we) ||
        (e_we != 0 && (mem_addr !== 11'(e_addr) || mem_wdata !== e_data))) begin
      errors++;
      $display("FAIL %s we=%b addr=%h data=%h expected we=%b addr=%h data=%h",
               tag, mem_we, mem_addr, mem_wdata, 2'(e_we), 11'(e_addr), e_data);
    end
  endtask

  task automatic model();
    int d = data_val;
    int h;
    e_we = 0;
    if (!st_fire) return;
    if (st_set_ofs) begin
      m_ofs = st_imm; m_lo = 0;
    end else if (st_manual) begin
      e_addr = (base_addr + st_imm) % 2048;
      if (st_mode == 0) begin
        e_we = 3; e_data = (pc_val * 65536 * 32) + d;
      end else if (st_mode == 1 || st_mode == 3) begin
        h = (st_mode == 1) ? (st_label * 16384 + (d % 16384)) : d;
        e_we = st_upper ? 2 : 1;
        e_data = st_upper ? 32'(h) << 16 : 32'(h);
      end
    end else if (st_auto) begin
      e_addr = (base_addr + m_ofs) % 2048;
      if (st_mode == 0) begin
        e_we = 3; e_data = (pc_val * 65536 * 32) + d;
        m_ofs = (m_ofs + 1) % 2048;
      end else if (st_mode == 3) begin
        if (!m_lo) begin
          e_we = 2; e_data = 32'(d) << 16; m_lo = 1;
        end else begin
          e_we = 1; e_data = 32'(d); m_lo = 0; m_ofs = (m_ofs + 1) % 2048;
        end
      end
    end
  endtask

  task automatic issue(bit f, bit so, bit man, bit au, int mode, bit up, int lab,
                       int imm, int base, int dat, int pcv, string tag);
    st_fire = f; st_set_ofs = so; st_manual = man; st_auto = au;
    st_mode = 2'(mode); st_upper = up; st_label = 2'(lab); st_imm = 11'(imm);
    base_addr = 11'(base); data_val = 16'(dat); pc_val = 11'(pcv);
    model();
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (mem_we !== 0 || mem_addr !== 0 || mem_wdata !== 0) begin
      errors++;
      $display("FAIL R1 we=%b addr=%h data=%h expected 0 0 0", mem_we, mem_addr, mem_wdata);
    end
    issue(1,0,0,1,3,0,0,0,12'h40,16'h1111,0,"R1 first half high at offset 0");
    issue(1,0,0,1,3,0,0,0,12'h40,16'h2222,0,"R1 second half");
    // R2 single full word
    issue(1,0,1,0,0,0,0,11'h23,11'h100,16'hBEEF,11'h5A5,"R2 full word");
    // R3 halves
    issue(1,0,1,0,3,1,0,11'h5,11'h200,16'hCAFE,11'h1,"R3 upper half");
    issue(1,0,1,0,3,0,0,11'h6,11'h200,16'hF00D,11'h1,"R3 lower half");
    // R4 labelled
    issue(1,0,1,0,1,1,2,11'h7,11'h10,16'hFFFF,0,"R4 labelled upper");
    issue(1,0,1,0,1,0,1,11'h8,11'h10,16'h4ABC,0,"R4 labelled lower");
    // R5, R6, R10 wrap in burst
    issue(1,1,0,0,0,0,0,11'h7FE,0,0,0,"R5 set offset no write");
    issue(1,0,0,1,0,0,0,0,11'h0,16'h0A0A,11'h11,"R6 burst full a");
    issue(1,0,0,1,0,0,0,0,11'h0,16'h0B0B,11'h12,"R10 burst full at 2047");
    issue(1,0,0,1,0,0,0,0,11'h0,16'h0C0C,11'h13,"R10 burst full wrapped");
    // R7 pairs
    issue(1,1,0,0,0,0,0,11'h10,0,0,0,"R5 set offset 0x10");
    issue(1,0,0,1,3,0,0,0,11'h300,16'hAAAA,0,"R7 pair high");
    issue(1,0,0,1,3,0,0,0,11'h300,16'hBBBB,0,"R7 pair low");
    issue(1,0,0,1,3,0,0,0,11'h300,16'hCCCC,0,"R7 next pair high");
    // set-offset mid pair
    issue(1,1,0,0,0,0,0,11'h30,0,0,0,"R5 reload mid pair");
    issue(1,0,0,1,3,0,0,0,11'h300,16'hDDDD,0,"R5 phase cleared high at new offset");
    issue(1,0,0,1,3,0,0,0,11'h300,16'hEEEE,0,"R7 low after reload");
    // R8 priority
    issue(1,1,1,1,0,0,0,11'h50,11'h1,16'h1234,0,"R8 setofs wins");
    issue(1,0,1,1,0,0,0,11'h9,11'h1,16'h5678,11'h7,"R8 manual wins over auto");
    issue(1,0,0,1,0,0,0,0,11'h1,16'h9ABC,11'h7,"R8 burst still at loaded offset");
    // R9 no-ops
    issue(1,0,0,0,0,0,0,11'h3,11'h1,16'h1,0,"R9 no enable");
    issue(1,0,1,0,2,0,0,11'h3,11'h1,16'h1,0,"R9 manual mode 2");
    issue(1,0,0,1,1,0,0,0,11'h1,16'h1,0,"R9 auto mode 1");
    issue(1,0,0,1,2,0,0,0,11'h1,16'h1,0,"R9 auto mode 2");
    issue(1,0,0,1,0,0,0,0,11'h1,16'h7777,11'h2,"R9 offset unchanged after no-ops");
    // R11 idle with fields set
    issue(0,0,1,1,0,1,3,11'h3,11'h4,16'hFFFF,11'h7FF,"R11 idle no write");
    // R10 single address wrap
    issue(1,0,1,0,0,0,0,11'h20,11'h7F0,16'h0102,11'h3,"R10 single wrap");
    // randomized mix, checked every cycle against the model
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 15);
      issue(r != 0, r == 1, r inside {2,3,4,5}, r >= 4, $urandom_range(0,3),
            1'($urandom), $urandom_range(0,3), $urandom_range(0,2047),
            $urandom_range(0,2047), $urandom_range(0,65535), $urandom_range(0,2047),
            "R6 R7 random mix");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule